// File: doc/BRIEF.md
# UART Break Generator and Detector

This block sends and recognises break conditions on a UART line. It works from a strobe that pulses for one clock once per bit time, and it leaves ordinary character framing, oversampling and baud generation to the logic around it. On the transmit side, a break request is held pending. At the next bit strobe where the surrounding transmitter reports a character boundary, the block drives its line output low for a length set by the character format. It then holds the line at mark for one more bit time before it lets go.

On the receive side, the block samples the line on each bit strobe and counts consecutive low samples. When the run reaches the threshold for the current format, it sets a sticky break flag. The flag raises an interrupt only when the interrupt enable is set, and software clears it by writing a one.

The format is given by three inputs: a 9-bit select, a 10-bit select and a two-stop-bit select. These place the format into one of four length groups, G0 to G3. A long-break option lengthens the generated break, and an extended-detection option raises the receive threshold.

Top module: `uart_break_unit`

## Requirements
- R1: Format group: G3 is 10-bit with two stop bits. G2 is 10-bit with one stop bit, or 9-bit with two. G1 is 9-bit with one stop bit, or 8-bit with two. G0 is 8-bit with one stop bit. With the long option clear, a generated break holds `txd_o` low for 10, 11, 12 or 13 bit times for G0, G1, G2 and G3.
- R2: With `long_brk_i` set, the generated break lasts 13, 14, 15 or 16 bit times for G0 to G3.
- R3: With `ext_det_i` clear, `brk_flag_o` sets on the bit strobe that samples the 10th, 11th, 12th or 13th consecutive low `rxd_i` (G0 to G3), and not after one sample fewer.
- R4: With `ext_det_i` set, the detection thresholds become 11, 12, 14 and 15 consecutive low samples for G0 to G3.
- R5: A high sample on `rxd_i` restarts the low count. The flag sets at most once per low run, so after a clear it stays clear until the line has been sampled high and then low for a full threshold again.
- R6: A pulse on `send_brk_i` is held pending. The break starts only on a bit strobe where `tx_boundary_i` is 1 and the generator is idle. No break starts while `tx_boundary_i` is 0.
- R7: After the low period, `txd_o` returns high and `tx_busy_o` stays 1 for one more bit time (mark). `tx_busy_o` is 1 whenever `txd_o` is low.
- R8: The flag is sticky. A cycle with `flag_wr_i`=1 and `flag_wdata_i`=1 clears it. A write with `flag_wdata_i`=0 leaves it set.
- R9: `irq_o` is 1 exactly when the flag is set and `brk_ie_i` is 1.
- R10: After reset, `txd_o`=1, `tx_busy_o`=0, `brk_flag_o`=0 and `irq_o`=0.
- R11: With `fmt10_i` set, the 9-bit select is ignored. For example, 10-bit, 9-bit and one stop bit together give the G2 length of 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-clock strobe once per bit time |
| fmt9_i | input | 1 | 9-bit data select |
| fmt10_i | input | 1 | 10-bit data select, overrides 9-bit |
| two_stop_i | input | 1 | Two stop bits |
| long_brk_i | input | 1 | Long generated break |
| ext_det_i | input | 1 | Extended detection threshold |
| send_brk_i | input | 1 | Break request pulse |
| tx_boundary_i | input | 1 | Transmitter is between characters |
| txd_o | output | 1 | Line output (1 = mark) |
| tx_busy_o | output | 1 | Break or trailing mark in progress |
| rxd_i | input | 1 | Received line |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data (1 clears) |
| brk_ie_i | input | 1 | Break interrupt enable |
| brk_flag_o | output | 1 | Sticky break detected flag |
| irq_o | output | 1 | Break interrupt request |

## Verification
The assertions assume that `bit_tick_i` is a single-clock pulse. They also assume that `rxd_i` and `tx_boundary_i` are only read on the strobe, so the line output may change only one clock after a strobe. The bench generates the strobe from a free-running divider, once every four clocks, and changes `rxd_i` and the controls only on falling clock edges. Format and option inputs are changed only while the generator is idle and the line is high, so no length is switched in the middle of a run.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef logic [1:0] fmt_grp_t;

  // 10-bit overrides 9-bit; a second stop bit adds one group step
  function automatic fmt_grp_t grp_of(input logic ten, input logic nine, input logic two);
    logic [1:0] base;
    base = ten ? 2'd2 : (nine ? 2'd1 : 2'd0);
    return base + {1'b0, two};
  endfunction
endpackage

// File: rtl/brk_len_sel.sv
module brk_len_sel
  import uart_brk_pkg::*;
#(
  parameter int LEN_W      = 5,
  parameter int SHORT_BASE = 10,
  parameter int LONG_BASE  = 13
) (
  input  logic             ten_i,
  input  logic             nine_i,
  input  logic             two_i,
  input  logic             long_i,
  input  logic             ext_i,
  output logic [LEN_W-1:0] gen_len_o,
  output logic [LEN_W-1:0] det_len_o
);
  localparam logic [LEN_W-1:0] SHORT_L = LEN_W'(SHORT_BASE);
  localparam logic [LEN_W-1:0] LONG_L  = LEN_W'(LONG_BASE);

  fmt_grp_t         grp;
  logic [LEN_W-1:0] grp_w;
  logic [LEN_W-1:0] ext_step;

  always_comb begin
    grp       = grp_of(ten_i, nine_i, two_i);
    grp_w     = LEN_W'(grp);
    gen_len_o = (long_i ? LONG_L : SHORT_L) + grp_w;
    // extended thresholds: one longer for G0/G1, two longer for G2/G3
    ext_step  = grp[1] ? LEN_W'(2) : LEN_W'(1);
    det_len_o = SHORT_L + grp_w + (ext_i ? ext_step : '0);
  end
endmodule

// File: rtl/brk_tx.sv
module brk_tx #(
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             boundary_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             txd_o,
  output logic             busy_o
);
  typedef enum logic [1:0] {TX_IDLE, TX_LOW, TX_MARK} tx_st_e;

  tx_st_e           st_q, st_d;
  logic             pend_q, pend_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q | req_i;
    cnt_d  = cnt_q;
    len_d  = len_q;
    if (tick_i) begin
      unique case (st_q)
        TX_IDLE: if (pend_q && boundary_i) begin
          st_d   = TX_LOW;
          pend_d = req_i;
          cnt_d  = LEN_W'(1);
          len_d  = len_i;
        end
        TX_LOW: begin
          if (cnt_q >= len_q) st_d = TX_MARK;
          else cnt_d = cnt_q + LEN_W'(1);
        end
        TX_MARK: st_d = TX_IDLE;
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

  assign txd_o  = (st_q != TX_LOW);
  assign busy_o = (st_q != TX_IDLE);
endmodule

// File: rtl/brk_rx.sv
module brk_rx #(
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rxd_i,
  input  logic [LEN_W-1:0] thr_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [LEN_W-1:0] run_q, run_d;
  logic             armed_q, armed_d;
  logic             flag_q, flag_d;
  logic             hit;

  always_comb begin
    run_d   = run_q;
    armed_d = armed_q;
    hit     = 1'b0;
    if (tick_i) begin
      if (rxd_i) begin
        run_d   = '0;
        armed_d = 1'b1;
      end else if (armed_q) begin
        run_d = run_q + LEN_W'(1);
        if (run_d >= thr_i) begin
          hit     = 1'b1;
          armed_d = 1'b0;
        end
      end
    end
    // a new detection wins over a clear in the same cycle
    flag_d = hit | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      armed_q <= armed_d;
      flag_q  <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_break_unit.sv
module uart_break_unit #(
  parameter int LEN_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic fmt9_i,
  input  logic fmt10_i,
  input  logic two_stop_i,
  input  logic long_brk_i,
  input  logic ext_det_i,
  input  logic send_brk_i,
  input  logic tx_boundary_i,
  output logic txd_o,
  output logic tx_busy_o,
  input  logic rxd_i,
  input  logic flag_wr_i,
  input  logic flag_wdata_i,
  input  logic brk_ie_i,
  output logic brk_flag_o,
  output logic irq_o
);
  logic [LEN_W-1:0] gen_len;
  logic [LEN_W-1:0] det_len;

  brk_len_sel #(.LEN_W(LEN_W)) i_len (
    .ten_i    (fmt10_i),
    .nine_i   (fmt9_i),
    .two_i    (two_stop_i),
    .long_i   (long_brk_i),
    .ext_i    (ext_det_i),
    .gen_len_o(gen_len),
    .det_len_o(det_len)
  );

  brk_tx #(.LEN_W(LEN_W)) i_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (bit_tick_i),
    .boundary_i(tx_boundary_i),
    .req_i     (send_brk_i),
    .len_i     (gen_len),
    .txd_o     (txd_o),
    .busy_o    (tx_busy_o)
  );

  brk_rx #(.LEN_W(LEN_W)) i_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(bit_tick_i),
    .rxd_i (rxd_i),
    .thr_i (det_len),
    .clr_i (flag_wr_i & flag_wdata_i),
    .flag_o(brk_flag_o)
  );

  assign irq_o = brk_flag_o & brk_ie_i;
endmodule

// File: rtl/uart_break_chk.sv
module uart_break_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic tx_boundary_i,
  input logic rxd_i,
  input logic flag_wr_i,
  input logic flag_wdata_i,
  input logic txd_o,
  input logic tx_busy_o,
  input logic brk_flag_o
);
  // R7: a low line is always reported busy
  p_low_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_o |-> tx_busy_o);

  // R7: the line returns to mark while still busy
  p_mark_after_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd_o) |-> tx_busy_o);

  // R6: a break begins only after a strobe at a character boundary
  p_start_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(txd_o) && !$past(tx_busy_o)) |-> $past(bit_tick_i && tx_boundary_i));

  // R5: detection follows a strobe that sampled a low line
  p_set_on_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_flag_o) |-> $past(bit_tick_i && !rxd_i));

  // R8: the flag drops only after a write of one
  p_clear_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_flag_o) |-> $past(flag_wr_i && flag_wdata_i));

  // R8: without a clearing write the flag holds
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_flag_o && !(flag_wr_i && flag_wdata_i)) |=> brk_flag_o);
endmodule

bind uart_break_unit uart_break_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_tick_i   (bit_tick_i),
  .tx_boundary_i(tx_boundary_i),
  .rxd_i        (rxd_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .txd_o        (txd_o),
  .tx_busy_o    (tx_busy_o),
  .brk_flag_o   (brk_flag_o)
);

// File: tb/test_uart_break_unit.sv
`timescale 1ns/1ps
module test_uart_break_unit;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic [1:0] div;
  logic fmt9, fmt10, two, lng, ext, send, bnd, rxd, wr, wdata, ie;
  logic txd, busy, flag, irq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div  <= '0;
      tick <= 1'b0;
    end else begin
      div  <= div + 2'd1;
      tick <= (div == 2'(TDIV - 1));
    end
  end

  uart_break_unit i_uart_break_unit (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick),
    .fmt9_i(fmt9), .fmt10_i(fmt10), .two_stop_i(two),
    .long_brk_i(lng), .ext_det_i(ext), .send_brk_i(send),
    .tx_boundary_i(bnd), .txd_o(txd), .tx_busy_o(busy),
    .rxd_i(rxd), .flag_wr_i(wr), .flag_wdata_i(wdata),
    .brk_ie_i(ie), .brk_flag_o(flag), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after one strobe is consumed
  task automatic wait_tick();
    while (!tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_fmt(input bit t10, input bit n9, input bit s2);
    fmt10 = t10; fmt9 = n9; two = s2;
  endtask

  task automatic clear_flag();
    wr = 1'b1; wdata = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = 1'b0;
  endtask

  // request a break and measure its low time in bit periods
  task automatic tx_case(input int exp_len, input string req);
    int low = 0;
    int guard = 0;
    send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    while (txd && guard < 400) begin @(negedge clk); guard++; end
    while (!txd && low < 400) begin @(negedge clk); low++; end
    check(low == exp_len * TDIV, req, low / TDIV, exp_len);
    check(busy == 1'b1, "R7 mark after break", busy, 1);
    while (busy) @(negedge clk);
  endtask

  // drive n low samples after a high one; report the flag
  task automatic rx_case(input int n, input bit exp, input string req);
    rxd = 1'b1;
    wait_tick();
    clear_flag();
    rxd = 1'b0;
    for (int i = 0; i < n; i++) wait_tick();
    check(flag == exp, req, flag, exp);
    rxd = 1'b1;
    wait_tick();
    clear_flag();
  endtask

  task automatic t_reset();
    check(txd == 1'b1, "R10 txd", txd, 1);
    check(busy == 1'b0, "R10 busy", busy, 0);
    check(flag == 1'b0, "R10 flag", flag, 0);
    check(irq == 1'b0, "R10 irq", irq, 0);
  endtask

  task automatic t_tx_lengths();
    set_fmt(0, 0, 0); lng = 0; tx_case(10, "R1 G0 short");
    set_fmt(0, 1, 0); tx_case(11, "R1 G1 short");
    set_fmt(0, 0, 1); tx_case(11, "R1 G1 8b two stop");
    set_fmt(0, 1, 1); tx_case(12, "R1 G2 short");
    set_fmt(1, 0, 1); tx_case(13, "R1 G3 short");
    lng = 1;
    set_fmt(0, 0, 0); tx_case(13, "R2 G0 long");
    set_fmt(0, 1, 0); tx_case(14, "R2 G1 long");
    set_fmt(1, 0, 0); tx_case(15, "R2 G2 long");
    set_fmt(1, 0, 1); tx_case(16, "R2 G3 long");
    lng = 0;
    set_fmt(1, 1, 0); tx_case(12, "R11 ten overrides nine");
    set_fmt(0, 0, 0);
  endtask

  task automatic t_boundary();
    bnd = 1'b0;
    send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    for (int i = 0; i < 12; i++) wait_tick();
    check(txd == 1'b1 && busy == 1'b0, "R6 held off without boundary", busy, 0);
    bnd = 1'b1;
    wait_tick();
    @(negedge clk);
    check(txd == 1'b0, "R6 pending break starts at boundary", txd, 0);
    while (busy) @(negedge clk);
  endtask

  task automatic t_rx_thresholds();
    ext = 0;
    set_fmt(0, 0, 0); rx_case(9, 0, "R3 G0 one short"); rx_case(10, 1, "R3 G0");
    set_fmt(0, 1, 0); rx_case(10, 0, "R3 G1 one short"); rx_case(11, 1, "R3 G1");
    set_fmt(1, 0, 0); rx_case(11, 0, "R3 G2 one short"); rx_case(12, 1, "R3 G2");
    set_fmt(1, 0, 1); rx_case(12, 0, "R3 G3 one short"); rx_case(13, 1, "R3 G3");
    ext = 1;
    set_fmt(0, 0, 0); rx_case(10, 0, "R4 G0 one short"); rx_case(11, 1, "R4 G0");
    set_fmt(0, 0, 1); rx_case(12, 1, "R4 G1");
    set_fmt(0, 1, 1); rx_case(13, 0, "R4 G2 one short"); rx_case(14, 1, "R4 G2");
    set_fmt(1, 0, 1); rx_case(14, 0, "R4 G3 one short"); rx_case(15, 1, "R4 G3");
    ext = 0;
    set_fmt(0, 0, 0);
  endtask

  task automatic t_once_per_run();
    rxd = 1'b1; wait_tick(); clear_flag();
    // 6 low, 1 high, 6 low: count restarts, no flag
    rxd = 1'b0; for (int i = 0; i < 6; i++) wait_tick();
    rxd = 1'b1; wait_tick();
    rxd = 1'b0; for (int i = 0; i < 6; i++) wait_tick();
    check(flag == 1'b0, "R5 high sample restarts count", flag, 0);
    for (int i = 0; i < 4; i++) wait_tick();
    check(flag == 1'b1, "R5 flag after full run", flag, 1);
    clear_flag();
    for (int i = 0; i < 15; i++) wait_tick();
    check(flag == 1'b0, "R5 no second flag in same run", flag, 0);
    rxd = 1'b1; wait_tick();
    rxd = 1'b0; for (int i = 0; i < 10; i++) wait_tick();
    check(flag == 1'b1, "R5 rearmed after high", flag, 1);
    rxd = 1'b1; wait_tick();
  endtask

  task automatic t_w1c_irq();
    ie = 1'b0;
    @(negedge clk);
    check(flag == 1'b1 && irq == 1'b0, "R9 irq masked", irq, 0);
    ie = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R9 irq enabled", irq, 1);
    wr = 1'b1; wdata = 1'b0;
    @(negedge clk);
    wr = 1'b0;
    check(flag == 1'b1, "R8 write zero keeps flag", flag, 1);
    clear_flag();
    check(flag == 1'b0, "R8 write one clears", flag, 0);
    check(irq == 1'b0, "R9 irq drops with flag", irq, 0);
    ie = 1'b0;
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fmt9 = 0; fmt10 = 0; two = 0; lng = 0; ext = 0;
    send = 0; bnd = 1; rxd = 1; wr = 0; wdata = 0; ie = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx_lengths();
    t_boundary();
    t_rx_thresholds();
    t_once_per_run();
    t_w1c_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule